// File: doc/BRIEF.md
# Configurable Split/Chained Interval Timer

This block is an up-counting interval timer whose counter and period storage can work in three ways. As one wide timer, the high and low words form a single 64-bit counter that is compared against a 64-bit period. In cascade mode, the high word runs as a prescaler, and each time it wraps the low word moves forward by one. In split mode, the two words are independent timers. The high timer is paced by an extra 4-bit prescaler, and each timer has its own match strobe.

A per-cycle `tick_i` input gates all counting. Software-style configuration arrives on plain inputs:
- a mode field;
- a per-half enable field;
- per-half run bits that hold a word at zero when low;
- load values and period values.

A one-cycle `load_i` pulse does two things. It copies the load values into the counters and prescaler as starting counts, and it arms both halves. A one-shot half disarms itself after its match. It counts again only after another load.

The registered match strobes are meant to feed the interrupt, event and output-shaping logic that sits outside this block.

Top module: `ivl_timer`

## Requirements
- R1: While `rst_ni` is low, both counter words, the prescaler and both match strobes read 0.
- R2: With `mode_i` = 2'b00, `{cnt_hi_o, cnt_lo_o}` behaves as one 64-bit counter:
  - it advances by 1 on each tick, with the carry passing from the low word into the high word;
  - `match_lo_o` pulses when the 64-bit value equal to `{prd_hi_i, prd_lo_i}` is consumed by a tick.
- R3: The enable field value 2'b10 is continuous. A tick that finds the counter equal to its period clears the counter to 0, and the matching strobe is high for the one cycle that follows that edge.
- R4: The enable field value 2'b01 is one-shot. After its match, the half keeps its counter value and gives no further strobe until the next `load_i`.
- R5: Enable field values 2'b00 and 2'b11 stop the half: its counter and strobe do not change.
- R6: With `mode_i` = 2'b11, the high word counts ticks up to `prd_hi_i` and wraps to 0. The low word advances only on the edge where the high word wraps. For example, a high word loaded with 200 and a period of 202 counts 200, 201, 202, 0, and at the wrap the low word goes from 3 to 4.
- R7: With `mode_i` = 2'b01, the 4-bit prescaler counts ticks up to `prd_psc_i` and then wraps to 0. The high word advances on that wrap edge and uses `en_hi_i` for its enable behaviour.
- R8: With `mode_i` = 2'b01, the low word counts every tick on its own under `en_lo_i`. `match_hi_o` pulses only in this mode.
- R9: `run_lo_i` = 0 holds the low word at 0. `run_hi_i` = 0 holds the high word and the prescaler at 0. In modes 2'b00 and 2'b11, counting needs both run bits.
- R10: `mode_i` = 2'b10 is reserved. In this mode nothing counts and no strobe is raised.
- R11: `load_i` sets the counters and the prescaler from `ld_lo_i`, `ld_hi_i` and `ld_psc_i`, and arms both halves. In the load cycle nothing advances and no strobe is raised.
- R12: A cycle without `tick_i` changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 wide, 01 split, 10 reserved, 11 cascade |
| en_lo_i | input | 2 | Low half enable: 00 off, 01 one-shot, 10 continuous |
| en_hi_i | input | 2 | High half enable, used in split mode only |
| run_lo_i | input | 1 | Low word release (0 holds it at 0) |
| run_hi_i | input | 1 | High word and prescaler release |
| load_i | input | 1 | Load the starting counts and arm both halves |
| ld_lo_i | input | HW | Low word starting count |
| ld_hi_i | input | HW | High word starting count |
| ld_psc_i | input | PW | Prescaler starting count |
| prd_lo_i | input | HW | Low word period |
| prd_hi_i | input | HW | High word period |
| prd_psc_i | input | PW | Prescaler period |
| tick_i | input | 1 | Count enable for this cycle |
| cnt_lo_o | output | HW | Low counter word |
| cnt_hi_o | output | HW | High counter word |
| psc_o | output | PW | Prescaler count |
| match_lo_o | output | 1 | Low half (or wide timer) match strobe |
| match_hi_o | output | 1 | High half match strobe (split mode) |

## Verification
Each mode is driven with three tick patterns: every cycle, every other cycle, and every third cycle. This separates advancing on the tick from advancing on the clock.

- In wide mode, the load values sit just under a 32-bit boundary. This exposes a missing carry into the high word and a period compare made on only one word.
- In cascade mode, the loaded counts reproduce the 200/202 example, so the edge where the low word steps can be checked.
- In split mode, the prescaler period and the two half periods are all different from each other. A strobe or wrap taken from the wrong stage then shows up.

Further phases cover the other behaviours. One phase lowers one run bit at a time. One switches the mode while the timer is running. Others use the reserved mode, the off and illegal enable values, and one-shot runs, where counting must stop exactly at the period.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE    = 2'b00,
    MODE_SPLIT   = 2'b01,
    MODE_GUARD   = 2'b10,
    MODE_CASCADE = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    EN_OFF  = 2'b00,
    EN_ONCE = 2'b01,
    EN_RUN  = 2'b10,
    EN_BAD  = 2'b11
  } ten_e;
endpackage

// File: rtl/ivl_step.sv
// One counter slice: advance, compare against period, wrap or hold.
module ivl_step #(
  parameter int N = 32
) (
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] prd_i,
  input  logic         adv_i,
  input  logic         cont_i,
  output logic [N-1:0] nxt_o,
  output logic         hit_o
);
  logic at_prd;

  always_comb begin
    at_prd = (cur_i == prd_i);
    hit_o  = adv_i & at_prd;
    if (!adv_i)      nxt_o = cur_i;
    else if (at_prd) nxt_o = cont_i ? '0 : cur_i;
    else             nxt_o = cur_i + N'(1);
  end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int HW = 32,
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    en_lo_i,
  input  logic [1:0]    en_hi_i,
  input  logic          run_lo_i,
  input  logic          run_hi_i,
  input  logic          load_i,
  input  logic [HW-1:0] ld_lo_i,
  input  logic [HW-1:0] ld_hi_i,
  input  logic [PW-1:0] ld_psc_i,
  input  logic [HW-1:0] prd_lo_i,
  input  logic [HW-1:0] prd_hi_i,
  input  logic [PW-1:0] prd_psc_i,
  input  logic          tick_i,
  output logic [HW-1:0] cnt_lo_o,
  output logic [HW-1:0] cnt_hi_o,
  output logic [PW-1:0] psc_o,
  output logic          match_lo_o,
  output logic          match_hi_o
);
  localparam int FW = 2 * HW;

  tmode_e        md;
  logic [FW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] psc_q, psc_d;
  logic          arm_lo_q, arm_lo_d, arm_hi_q, arm_hi_d;
  logic          mlo_q, mlo_d, mhi_q, mhi_d;
  logic          act_lo, act_hi, run_both;

  // wide slice
  logic [FW-1:0] nxt_w;
  logic          hit_w, adv_w, cont_w;
  // prescaler slice
  logic [PW-1:0] nxt_p;
  logic          hit_p, adv_p;
  // half-word slices, index 0 = low, 1 = high
  logic [HW-1:0] cur_h [2];
  logic [HW-1:0] prd_h [2];
  logic [HW-1:0] nxt_h [2];
  logic [1:0]    adv_h, cont_h, hit_h;

  always_comb begin
    md       = tmode_e'(mode_i);
    run_both = run_lo_i & run_hi_i;
    act_lo   = arm_lo_q & ((en_lo_i == EN_ONCE) | (en_lo_i == EN_RUN));
    act_hi   = arm_hi_q & ((en_hi_i == EN_ONCE) | (en_hi_i == EN_RUN));
    adv_w    = (md == MODE_WIDE) & tick_i & run_both & act_lo;
    cont_w   = (en_lo_i == EN_RUN);
    adv_p    = (md == MODE_SPLIT) & tick_i & run_hi_i & act_hi;
    cur_h[0] = cnt_q[HW-1:0];
    cur_h[1] = cnt_q[FW-1:HW];
    prd_h[0] = prd_lo_i;
    prd_h[1] = prd_hi_i;
    adv_h[1] = ((md == MODE_CASCADE) & tick_i & run_both & act_lo) |
               ((md == MODE_SPLIT) & hit_p);
    adv_h[0] = ((md == MODE_CASCADE) & hit_h[1]) |
               ((md == MODE_SPLIT) & tick_i & run_lo_i & act_lo);
    cont_h[1] = (md == MODE_CASCADE) | (en_hi_i == EN_RUN);
    cont_h[0] = (en_lo_i == EN_RUN);
  end

  ivl_step #(.N(FW)) u_wide (
    .cur_i(cnt_q), .prd_i({prd_hi_i, prd_lo_i}), .adv_i(adv_w),
    .cont_i(cont_w), .nxt_o(nxt_w), .hit_o(hit_w)
  );

  ivl_step #(.N(PW)) u_psc (
    .cur_i(psc_q), .prd_i(prd_psc_i), .adv_i(adv_p),
    .cont_i(1'b1), .nxt_o(nxt_p), .hit_o(hit_p)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_half
    ivl_step #(.N(HW)) u_half (
      .cur_i(cur_h[gi]), .prd_i(prd_h[gi]), .adv_i(adv_h[gi]),
      .cont_i(cont_h[gi]), .nxt_o(nxt_h[gi]), .hit_o(hit_h[gi])
    );
  end

  // next-state selection
  always_comb begin
    cnt_d    = cnt_q;
    psc_d    = psc_q;
    arm_lo_d = arm_lo_q;
    arm_hi_d = arm_hi_q;
    mlo_d    = 1'b0;
    mhi_d    = 1'b0;
    if (load_i) begin
      cnt_d    = {ld_hi_i, ld_lo_i};
      psc_d    = ld_psc_i;
      arm_lo_d = (en_lo_i == EN_ONCE) | (en_lo_i == EN_RUN);
      arm_hi_d = (en_hi_i == EN_ONCE) | (en_hi_i == EN_RUN);
    end else begin
      unique case (md)
        MODE_WIDE: begin
          cnt_d = nxt_w;
          mlo_d = hit_w;
          if (hit_w && !cont_w) arm_lo_d = 1'b0;
        end
        MODE_CASCADE: begin
          cnt_d = {nxt_h[1], nxt_h[0]};
          mlo_d = hit_h[0];
          if (hit_h[0] && !cont_h[0]) arm_lo_d = 1'b0;
        end
        MODE_SPLIT: begin
          cnt_d = {nxt_h[1], nxt_h[0]};
          psc_d = nxt_p;
          mlo_d = hit_h[0];
          mhi_d = hit_h[1];
          if (hit_h[0] && !cont_h[0]) arm_lo_d = 1'b0;
          if (hit_h[1] && !cont_h[1]) arm_hi_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (!run_lo_i) cnt_d[HW-1:0] = '0;
    if (!run_hi_i) begin
      cnt_d[FW-1:HW] = '0;
      psc_d          = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      psc_q    <= '0;
      arm_lo_q <= 1'b0;
      arm_hi_q <= 1'b0;
      mlo_q    <= 1'b0;
      mhi_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      psc_q    <= psc_d;
      arm_lo_q <= arm_lo_d;
      arm_hi_q <= arm_hi_d;
      mlo_q    <= mlo_d;
      mhi_q    <= mhi_d;
    end
  end

  assign cnt_lo_o   = cnt_q[HW-1:0];
  assign cnt_hi_o   = cnt_q[FW-1:HW];
  assign psc_o      = psc_q;
  assign match_lo_o = mlo_q;
  assign match_hi_o = mhi_q;
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
  parameter int HW = 32,
  parameter int PW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic [1:0]    en_lo_i,
  input logic [1:0]    en_hi_i,
  input logic          run_lo_i,
  input logic          run_hi_i,
  input logic          load_i,
  input logic [HW-1:0] ld_lo_i,
  input logic [HW-1:0] ld_hi_i,
  input logic [PW-1:0] ld_psc_i,
  input logic [HW-1:0] prd_lo_i,
  input logic [HW-1:0] prd_hi_i,
  input logic [PW-1:0] prd_psc_i,
  input logic          tick_i,
  input logic [HW-1:0] cnt_lo_o,
  input logic [HW-1:0] cnt_hi_o,
  input logic [PW-1:0] psc_o,
  input logic          match_lo_o,
  input logic          match_hi_o
);
  p_hold_no_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && run_lo_i && run_hi_i) |=>
      ($stable(cnt_lo_o) && $stable(cnt_hi_o) && $stable(psc_o)));

  p_off_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && en_lo_i == 2'b00 && !load_i && run_lo_i && run_hi_i) |=>
      ($stable(cnt_lo_o) && $stable(cnt_hi_o) && !match_lo_o));

  p_hi_strobe_split_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b01 || load_i) |=> !match_hi_o);

  p_release_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_lo_i |=> (cnt_lo_o == '0));

  p_release_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_hi_i |=> (cnt_hi_o == '0 && psc_o == '0));

  p_guard_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !load_i && run_lo_i && run_hi_i) |=>
      ($stable(cnt_lo_o) && $stable(cnt_hi_o) && !match_lo_o && !match_hi_o));

  p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && run_lo_i && run_hi_i) |=>
      (cnt_lo_o == $past(ld_lo_i) && cnt_hi_o == $past(ld_hi_i) &&
       psc_o == $past(ld_psc_i) && !match_lo_o && !match_hi_o));
endmodule

bind ivl_timer ivl_timer_chk #(.HW(HW), .PW(PW)) u_chk (.*);

// File: tb/sim_ivl_timer.sv
module sim_ivl_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [1:0]  mode, en_lo, en_hi;
  logic        run_lo, run_hi, load, tick;
  logic [31:0] ld_lo, ld_hi, prd_lo, prd_hi;
  logic [3:0]  ld_psc, prd_psc;
  logic [31:0] cnt_lo, cnt_hi;
  logic [3:0]  psc;
  logic        m_lo, m_hi;

  int    checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  ivl_timer #(.HW(32), .PW(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en_lo_i(en_lo), .en_hi_i(en_hi),
    .run_lo_i(run_lo), .run_hi_i(run_hi), .load_i(load), .ld_lo_i(ld_lo),
    .ld_hi_i(ld_hi), .ld_psc_i(ld_psc), .prd_lo_i(prd_lo), .prd_hi_i(prd_hi),
    .prd_psc_i(prd_psc), .tick_i(tick), .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi),
    .psc_o(psc), .match_lo_o(m_lo), .match_hi_o(m_hi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  longint unsigned r_lo, r_hi, r_p;
  bit r_arm_lo, r_arm_hi, r_mlo, r_mhi;

  function automatic bit en_ok(logic [1:0] e);
    return (e == 2'b01) || (e == 2'b10);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_lo = 0; r_hi = 0; r_p = 0;
      r_arm_lo = 0; r_arm_hi = 0; r_mlo = 0; r_mhi = 0;
    end else begin
      longint unsigned w, pw;
      r_mlo = 0; r_mhi = 0;
      if (load) begin
        r_lo = ld_lo; r_hi = ld_hi; r_p = ld_psc;
        r_arm_lo = en_ok(en_lo); r_arm_hi = en_ok(en_hi);
      end else if (mode == 2'b00) begin
        if (tick && run_lo && run_hi && r_arm_lo && en_ok(en_lo)) begin
          w  = (r_hi << 32) | r_lo;
          pw = (longint'(prd_hi) << 32) | longint'(prd_lo);
          if (w == pw) begin
            r_mlo = 1;
            if (en_lo == 2'b10) w = 0; else r_arm_lo = 0;
          end else w = w + 1;
          r_lo = w & 64'hFFFF_FFFF; r_hi = w >> 32;
        end
      end else if (mode == 2'b11) begin
        if (tick && run_lo && run_hi && r_arm_lo && en_ok(en_lo)) begin
          if (r_hi == prd_hi) begin
            r_hi = 0;
            if (r_lo == prd_lo) begin
              r_mlo = 1;
              if (en_lo == 2'b10) r_lo = 0; else r_arm_lo = 0;
            end else r_lo = (r_lo + 1) & 64'hFFFF_FFFF;
          end else r_hi = (r_hi + 1) & 64'hFFFF_FFFF;
        end
      end else if (mode == 2'b01) begin
        if (tick && run_lo && r_arm_lo && en_ok(en_lo)) begin
          if (r_lo == prd_lo) begin
            r_mlo = 1;
            if (en_lo == 2'b10) r_lo = 0; else r_arm_lo = 0;
          end else r_lo = (r_lo + 1) & 64'hFFFF_FFFF;
        end
        if (tick && run_hi && r_arm_hi && en_ok(en_hi)) begin
          if (r_p == prd_psc) begin
            r_p = 0;
            if (r_hi == prd_hi) begin
              r_mhi = 1;
              if (en_hi == 2'b10) r_hi = 0; else r_arm_hi = 0;
            end else r_hi = (r_hi + 1) & 64'hFFFF_FFFF;
          end else r_p = (r_p + 1) & 64'hF;
        end
      end
      if (!run_lo) r_lo = 0;
      if (!run_hi) begin r_hi = 0; r_p = 0; end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (cnt_lo !== 32'(r_lo) || cnt_hi !== 32'(r_hi) || psc !== 4'(r_p) ||
          m_lo !== r_mlo || m_hi !== r_mhi) begin
        fails++;
        $display("FAIL %s: act lo=%h hi=%h psc=%h mlo=%b mhi=%b exp lo=%h hi=%h psc=%h mlo=%b mhi=%b",
                 cur_req, cnt_lo, cnt_hi, psc, m_lo, m_hi,
                 32'(r_lo), 32'(r_hi), 4'(r_p), r_mlo, r_mhi);
      end
    end
  end

  task automatic expect_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // pat: 0 every cycle, 1 every other cycle, 2 every third cycle
  task automatic run(int n, int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      case (pat)
        0: tick = 1'b1;
        1: tick = (cyc % 2) == 0;
        default: tick = (cyc % 3) == 0;
      endcase
    end
  endtask

  task automatic do_load(logic [31:0] lo, logic [31:0] hi, logic [3:0] p);
    @(negedge clk);
    ld_lo = lo; ld_hi = hi; ld_psc = p; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; mode = 2'b00; en_lo = 2'b00; en_hi = 2'b00;
    run_lo = 0; run_hi = 0; load = 0; tick = 0;
    ld_lo = 0; ld_hi = 0; ld_psc = 0; prd_lo = 0; prd_hi = 0; prd_psc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_eq("R1", "cnt_lo", cnt_lo, 0);
    expect_eq("R1", "cnt_hi", cnt_hi, 0);
    expect_eq("R1", "psc", psc, 0);
    expect_eq("R1", "strobes", {m_lo, m_hi}, 0);
    rst_n = 1;

    // R2 R3 R11 wide mode, carry across the word boundary
    cur_req = "R2";
    run_lo = 1; run_hi = 1; en_lo = 2'b10; prd_hi = 1; prd_lo = 1;
    tick = 0;
    do_load(32'hFFFF_FFFE, 0, 0);
    expect_eq("R11", "loaded lo", cnt_lo, 32'hFFFF_FFFE);
    tick = 1;
    @(negedge clk); @(negedge clk);
    expect_eq("R2", "carry hi", cnt_hi, 1);
    expect_eq("R2", "carry lo", cnt_lo, 0);
    run(30, 0);
    cur_req = "R3";
    prd_hi = 0; prd_lo = 3;
    do_load(0, 0, 0);
    run(40, 1);
    run(40, 2);

    // R4 one-shot, R12 idle ticks
    cur_req = "R4";
    en_lo = 2'b01; prd_lo = 5;
    do_load(1, 0, 0);
    run(30, 0);
    expect_eq("R4", "held at period", cnt_lo, 5);
    cur_req = "R12";
    tick = 0;
    run(1, 1);
    run(20, 2);

    // R5 off and illegal enable
    cur_req = "R5";
    en_lo = 2'b00;
    do_load(2, 0, 0);
    run(10, 0);
    expect_eq("R5", "off hold", cnt_lo, 2);
    en_lo = 2'b11;
    run(10, 0);

    // R6 cascade, example counts
    cur_req = "R6";
    mode = 2'b11; en_lo = 2'b10; prd_hi = 202; prd_lo = 4;
    tick = 0;
    do_load(3, 200, 0);
    tick = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    expect_eq("R6", "prescale wrap", cnt_hi, 0);
    expect_eq("R6", "low step", cnt_lo, 4);
    prd_hi = 2;
    run(60, 0);
    run(60, 1);
    en_lo = 2'b01;
    do_load(0, 0, 0);
    run(40, 2);

    // R7 R8 split mode
    cur_req = "R7";
    mode = 2'b01; en_hi = 2'b10; en_lo = 2'b01;
    prd_psc = 2; prd_hi = 16; prd_lo = 5;
    tick = 0;
    do_load(0, 15, 1);
    tick = 1;
    repeat (5) @(negedge clk);
    expect_eq("R7", "hi wrap", cnt_hi, 0);
    expect_eq("R7", "hi strobe", m_hi, 1);
    cur_req = "R8";
    prd_hi = 3; en_lo = 2'b10;
    do_load(0, 0, 0);
    run(80, 0);
    run(80, 2);

    // R9 run bits
    cur_req = "R9";
    run_hi = 0;
    run(3, 0);
    expect_eq("R9", "hi held", cnt_hi, 0);
    expect_eq("R9", "psc held", psc, 0);
    run_hi = 1;
    run(20, 1);
    mode = 2'b00; run_lo = 0;
    run(10, 0);
    expect_eq("R9", "lo held", cnt_lo, 0);
    run_lo = 1;
    mode = 2'b11;          // switch without reload
    run(40, 0);

    // R10 reserved mode
    cur_req = "R10";
    mode = 2'b10;
    run(20, 0);
    expect_eq("R10", "no strobe", {m_lo, m_hi}, 0);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule